// File: doc/BRIEF.md
# Skew-Absorbing Two-Operand Node for Late Misprediction Recovery

This block wraps a two-operand combinational function inside a datapath that repairs mispredictions late. Every cycle each operand input carries one token. The token is either valid data or an invalid marker. An invalid marker is one wavefront of damage from a single misprediction. The same wavefront can reach the two inputs in different cycles. When it first touches either input, the node produces a single invalid result. Until the wavefront reaches the second input, the node queues the valid data still arriving there and pairs it, oldest first, with live data from the input already hit. When the marker reaches the trailing input, the node uses up a queued item and stores nothing. After that, live data flows straight through again.

The node keeps its backlog in a small in-order queue of parameterised depth. The depth sets how many wavefronts one input may lead the other by. A register downstream of the function takes in only valid results, so a state element reached by the wavefront leaves its contents unchanged. The operation is chosen by a parameter, and addition is the default.

Top module: `wave_node`

## Requirements
- R1: In a cycle where a wavefront arrives at the node for the first time, y_vld is 0. This happens when an invalid token (valid bit 0) appears on an input while no backlog exists, or on the input that leads the backlog.
- R2: With no backlog and both inputs valid, y_vld is 1 in the same cycle and y_dat is a_dat + b_dat modulo 2^DATA_W (the default addition, OP = OP_ADD).
- R3: When the trailing input receives its invalid token while the leading input carries valid data, the result is valid. Each wavefront gives exactly one invalid result.
- R4: Queued operands are used in the order they arrived. The sequence of valid results equals the element-wise function of the k-th valid item of input a and the k-th valid item of input b.
- R5: The trailing input's invalid token reduces the backlog by one in the next cycle. Once the backlog is empty, live data from both inputs is used directly, and every queued item is eventually used.
- R6: The backlog never grows beyond DEPTH entries, provided neither input leads the other by more than DEPTH wavefronts.
- R7: hold_dat takes y_dat on the clock edge after a valid result. Otherwise it keeps its value, so an invalid token never updates it.
- R8: While rst_n is low the backlog is empty and hold_dat is 0. With both inputs invalid, y_vld is 0.
- R9: Over any run that ends with both inputs having seen the same number of invalid tokens, the number of invalid results equals the number of wavefronts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Input a token: 1 valid data, 0 wavefront marker |
| a_dat | input | DATA_W | Input a data, ignored when a_vld is 0 |
| b_vld | input | 1 | Input b token: 1 valid data, 0 wavefront marker |
| b_dat | input | DATA_W | Input b data, ignored when b_vld is 0 |
| y_vld | output | 1 | Result token valid bit |
| y_dat | output | DATA_W | Result data, zero when y_vld is 0 |
| hold_dat | output | DATA_W | Register loaded only with valid results |

## Verification
The properties assume that every wavefront reaches both inputs, in either order, and that the lead of one input over the other never exceeds DEPTH wavefronts. Without that assumption, the queue bound and the one-invalid-per-wavefront accounting have no meaning. The stimulus keeps running counts of the markers sent on each input. It only starts a new wavefront on an input when the resulting lead stays within DEPTH, and it catches up the trailing input at random delays. A final drain forces the lagging input to catch up, so every wavefront closes before the totals are compared. Marker cycles carry random data on the data lines to show that the data is ignored.

// File: rtl/wave_pkg.sv
package wave_pkg;

  // Which operand currently owns the backlog queue (the input the wavefront
  // has not reached yet).
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  // Node operation choices.
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2
  } op_e;

endpackage

// File: rtl/wave_fifo.sv
module wave_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) bump = '0;
    else                        bump = p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;
  assign rdata = mem_q[rd_q];
  assign wr_en = push && (!full || pop);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_en) wr_d = bump(wr_q);
    if (pop)   rd_d = bump(rd_q);
    if (wr_en && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!wr_en && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage carries no reset; a clock enable guards each entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_q == PTR_W'(g))) mem_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/wave_steer.sv
module wave_steer
  import wave_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              a_vld,
  input  logic [DATA_W-1:0] a_dat,
  input  logic              b_vld,
  input  logic [DATA_W-1:0] b_dat,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  input  side_e             side_q,
  output logic              push,
  output logic              pop,
  output logic [DATA_W-1:0] push_dat,
  output logic [DATA_W-1:0] op_x,
  output logic [DATA_W-1:0] op_y,
  output logic              res_vld,
  output logic              side_set,
  output side_e             side_val
);

  // Rule: live valid data joins its input's logical queue; a result is valid
  // exactly when both logical queues hold an item. Only one side can hold a
  // backlog, so a single physical queue plus an owner flag is enough.
  always_comb begin
    push     = 1'b0;
    pop      = 1'b0;
    push_dat = '0;
    op_x     = a_dat;
    op_y     = b_dat;
    res_vld  = 1'b0;
    side_set = 1'b0;
    side_val = SIDE_A;
    if (q_empty) begin
      if (a_vld && b_vld) begin
        res_vld = 1'b1;
      end else if (a_vld) begin
        push     = 1'b1;
        push_dat = a_dat;
        side_set = 1'b1;
        side_val = SIDE_A;
      end else if (b_vld) begin
        push     = 1'b1;
        push_dat = b_dat;
        side_set = 1'b1;
        side_val = SIDE_B;
      end
    end else if (side_q == SIDE_A) begin
      op_x = q_head;
      if (b_vld) begin
        pop     = 1'b1;
        res_vld = 1'b1;
      end
      if (a_vld) begin
        push     = 1'b1;
        push_dat = a_dat;
      end
    end else begin
      op_y = q_head;
      if (a_vld) begin
        pop     = 1'b1;
        res_vld = 1'b1;
      end
      if (b_vld) begin
        push     = 1'b1;
        push_dat = b_dat;
      end
    end
  end

endmodule

// File: rtl/wave_op.sv
module wave_op
  import wave_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter op_e OP     = OP_ADD
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] r
);

  if (OP == OP_ADD) begin : g_add
    assign r = x + y;
  end else if (OP == OP_SUB) begin : g_sub
    assign r = x - y;
  end else begin : g_xor
    assign r = x ^ y;
  end

endmodule

// File: rtl/wave_node.sv
module wave_node
  import wave_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 1,
  parameter op_e OP     = OP_ADD,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_vld,
  input  logic [DATA_W-1:0] a_dat,
  input  logic              b_vld,
  input  logic [DATA_W-1:0] b_dat,
  output logic              y_vld,
  output logic [DATA_W-1:0] y_dat,
  output logic [DATA_W-1:0] hold_dat
);

  logic              q_push, q_pop, q_empty, q_full;
  logic [DATA_W-1:0] q_wdata, q_head;
  logic [CNT_W-1:0]  q_count;
  logic [DATA_W-1:0] op_x, op_y, op_r;
  logic              res_vld, side_set;
  side_e             side_q, side_d, side_val;
  logic [DATA_W-1:0] hold_q, hold_d;

  wave_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .wdata (q_wdata),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full),
    .count (q_count)
  );

  wave_steer #(.DATA_W(DATA_W)) u_steer (
    .a_vld    (a_vld),
    .a_dat    (a_dat),
    .b_vld    (b_vld),
    .b_dat    (b_dat),
    .q_empty  (q_empty),
    .q_head   (q_head),
    .side_q   (side_q),
    .push     (q_push),
    .pop      (q_pop),
    .push_dat (q_wdata),
    .op_x     (op_x),
    .op_y     (op_y),
    .res_vld  (res_vld),
    .side_set (side_set),
    .side_val (side_val)
  );

  wave_op #(.DATA_W(DATA_W), .OP(OP)) u_op (
    .x (op_x),
    .y (op_y),
    .r (op_r)
  );

  assign y_vld    = res_vld;
  assign y_dat    = res_vld ? op_r : '0;
  assign hold_dat = hold_q;

  // Next-state logic.
  always_comb begin
    side_d = side_q;
    if (side_set) side_d = side_val;
    hold_d = hold_q;
    if (res_vld) hold_d = op_r;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= SIDE_A;
      hold_q <= '0;
    end else begin
      side_q <= side_d;
      hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/wave_node_chk.sv
module wave_node_chk
  import wave_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 1,
  parameter op_e OP     = OP_ADD,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_vld,
  input logic [DATA_W-1:0] a_dat,
  input logic              b_vld,
  input logic [DATA_W-1:0] b_dat,
  input logic              y_vld,
  input logic [DATA_W-1:0] y_dat,
  input logic [DATA_W-1:0] hold_dat,
  input logic              q_empty,
  input logic              q_full,
  input logic [CNT_W-1:0]  q_count,
  input logic              q_push,
  input logic              q_pop,
  input side_e             side_q
);

  logic lead_live, lead_dead;
  assign lead_live = (side_q == SIDE_A) ? b_vld : a_vld;
  assign lead_dead = !lead_live;

  // R1: first arrival of a wavefront gives an invalid result
  a_r1_first_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && !(a_vld && b_vld)) |-> !y_vld);

  // R1: a new wavefront on the leading input while a backlog exists
  a_r1_first_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && lead_dead) |-> !y_vld);

  // R2: direct path with both inputs valid
  if (OP == OP_ADD) begin : g_sum
    a_r2_direct_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (q_empty && a_vld && b_vld) |-> (y_vld && (y_dat == DATA_W'(a_dat + b_dat))));
  end

  // R3: the trailing marker does not cost a second invalid result
  a_r3_catchup_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && lead_live) |-> y_vld);

  // R5: trailing marker with a live leader shrinks the backlog by one
  a_r5_backlog_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && lead_live &&
     (((side_q == SIDE_A) && !a_vld) || ((side_q == SIDE_B) && !b_vld)))
    |=> (q_count == CNT_W'($past(q_count) - 1'b1)));

  // R6: the queue never takes a push it cannot hold
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && !q_pop) |-> !q_full);

  // R7: hold register loads valid results only
  a_r7_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !y_vld |=> $stable(hold_dat));

  a_r7_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |=> (hold_dat == $past(y_dat)));

  // R8: both inputs invalid never produce a valid result
  always_comb begin
    if (rst_n && !a_vld && !b_vld) begin
      a_r8_idle_invalid: assert (!y_vld);
    end
  end

endmodule

bind wave_node wave_node_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OP(OP)) u_wave_node_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_vld    (a_vld),
  .a_dat    (a_dat),
  .b_vld    (b_vld),
  .b_dat    (b_dat),
  .y_vld    (y_vld),
  .y_dat    (y_dat),
  .hold_dat (hold_dat),
  .q_empty  (q_empty),
  .q_full   (q_full),
  .q_count  (q_count),
  .q_push   (q_push),
  .q_pop    (q_pop),
  .side_q   (side_q)
);

// File: tb/test_wave_node.sv
`timescale 1ns/1ps
module test_wave_node;
  import wave_pkg::*;

  localparam int W      = 16;
  localparam int DEPTH  = 2;
  localparam int NITEM  = 2048;
  localparam int NRUN   = 1200;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_vld, b_vld;
  logic [W-1:0] a_dat, b_dat;
  logic         y_vld;
  logic [W-1:0] y_dat, hold_dat;

  wave_node #(.DATA_W(W), .DEPTH(DEPTH), .OP(OP_ADD)) i_wave_node (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_vld    (a_vld),
    .a_dat    (a_dat),
    .b_vld    (b_vld),
    .b_dat    (b_dat),
    .y_vld    (y_vld),
    .y_dat    (y_dat),
    .hold_dat (hold_dat)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  logic [W-1:0] a_item [NITEM];
  logic [W-1:0] b_item [NITEM];
  logic [W-1:0] sb [$];
  int ia = 0, ib = 0, wa = 0, wb = 0, npair = 0;
  bit exp_inv = 1'b0;
  int n_inv_seen = 0;
  logic [W-1:0] last_good = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: sends one token per input per cycle and pushes expected results.
  task automatic drive_cycle(input bit allow_new);
    bit inv_a, inv_b;
    int old_max, new_max;
    // R6: a new wavefront starts only while the lead stays within DEPTH.
    if (wa < wb) inv_a = !allow_new || (($urandom % 3) == 0);
    else         inv_a = allow_new && ((wa - wb) < DEPTH) && (($urandom % 9) == 0);
    if (wb < wa) inv_b = !allow_new || (($urandom % 3) == 0);
    else         inv_b = allow_new && ((wb - wa) < DEPTH) && (($urandom % 9) == 0);
    old_max = (wa > wb) ? wa : wb;
    @(posedge clk);
    #1;
    a_vld = !inv_a;
    b_vld = !inv_b;
    if (inv_a) begin a_dat = W'($urandom); wa++; end
    else       begin a_dat = a_item[ia];   ia++; end
    if (inv_b) begin b_dat = W'($urandom); wb++; end
    else       begin b_dat = b_item[ib];   ib++; end
    new_max = (wa > wb) ? wa : wb;
    exp_inv = (new_max > old_max);
    while (npair < ((ia < ib) ? ia : ib)) begin
      sb.push_back(W'(a_item[npair] + b_item[npair]));
      npair++;
    end
    run = 1'b1;
  endtask

  // Monitor: samples on the falling edge, away from the driving edge.
  initial begin
    forever begin
      @(negedge clk);
      if (run) begin
        // R1 R3: invalid exactly on the first arrival of each wavefront
        chk(y_vld == !exp_inv, "R1 R3 valid flag", longint'(y_vld), longint'(!exp_inv));
        // R7: hold register reflects the last valid result only
        chk(hold_dat == last_good, "R7 hold register", longint'(hold_dat), longint'(last_good));
        if (y_vld) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R4 unexpected result", longint'(y_dat), 0);
          end else begin
            logic [W-1:0] e;
            e = sb.pop_front();
            // R2 R4 R6: ordered pairing equals the wavefront-free result
            chk(y_dat == e, "R2 R4 R6 result data", longint'(y_dat), longint'(e));
          end
          last_good = y_dat;
        end else begin
          n_inv_seen++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NITEM; k++) begin
      a_item[k] = W'($urandom);
      b_item[k] = W'($urandom);
    end
    rst_n = 1'b0;
    a_vld = 1'b0;
    b_vld = 1'b0;
    a_dat = '0;
    b_dat = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(hold_dat == '0, "R8 hold after reset", longint'(hold_dat), 0);
    chk(y_vld == 1'b0, "R8 idle output", longint'(y_vld), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    for (int c = 0; c < NRUN; c++) drive_cycle(1'b1);
    while (wa != wb) drive_cycle(1'b0);
    for (int c = 0; c < 4; c++) drive_cycle(1'b0);
    @(negedge clk);
    run = 1'b0;
    @(posedge clk);
    #1;
    a_vld = 1'b0;
    b_vld = 1'b0;

    // R5: every queued operand was used
    chk(sb.size() == 0, "R5 leftover expected results", longint'(sb.size()), 0);
    // R9: one invalid result per wavefront
    chk(n_inv_seen == wa, "R9 invalid result count", longint'(n_inv_seen), longint'(wa));
    chk(wa > 20, "R9 wavefront coverage", longint'(wa), 21);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule